// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the addressing fields of a memory operand into an address for a 16-bit processor that uses segmented memory. From a mode code, a base register choice, an index register choice and a displacement, it forms the 16-bit operand offset, called the effective address. It then picks one of four segment registers and forms the 20-bit physical address from that segment and the offset.

The caller presents the current contents of the two base registers (BX, BP), the two index registers (SI, DI) and the four segment registers (code, data, stack, extra). A segment override from a prefix decoder may be applied along with them. The datapath is combinational. A parameter places one register stage on the outputs. With that stage fitted, which is the default, every input set appears at the outputs one clock later, and reset clears the outputs to zero.

Top module: `seg_ea_gen`

## Requirements
- R1: Mode codes 0 (direct) and 7 (reserved) give an effective address equal to the full 16-bit `disp_in`, whatever the value of `disp_wide`, with no register added.
- R2: Mode 1 gives the selected base register as the effective address, with `base_pick` 0 choosing BX and 1 choosing BP. Mode 2 gives the selected index register, with `index_pick` 0 choosing SI and 1 choosing DI.
- R3: Mode 3 adds the displacement to the base register, and mode 4 adds it to the index register. When `disp_wide` is 0, only bits 7:0 of `disp_in` are used, sign-extended from bit 7. When `disp_wide` is 1, all 16 bits are used.
- R4: Mode 5 adds the base register and the index register. Mode 6 adds the base register, the index register and the displacement.
- R5: Every effective-address sum wraps modulo 2^16.
- R6: Without an override, the segment code on `seg_out` is 2 (stack) when the mode uses a base register (modes 1, 3, 5, 6) and `base_pick` is 1 (BP). In every other case it is 1 (data). The segment codes are 0 for code, 1 for data, 2 for stack and 3 for extra.
- R7: When `ovr_en` is 1, `seg_out` equals `ovr_seg` in every mode, using the same segment codes.
- R8: `phys_out` equals the value of the selected segment register shifted left by 4 bits, plus the effective address, kept to 20 bits.
- R9: With the output stage fitted, the outputs show the result for the inputs present one clock earlier. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| am_mode | input | 3 | Addressing mode code (0 to 7) |
| base_pick | input | 1 | Base register choice: 0 BX, 1 BP |
| index_pick | input | 1 | Index register choice: 0 SI, 1 DI |
| disp_in | input | 16 | Displacement, or the direct address in mode 0 and mode 7 |
| disp_wide | input | 1 | 1: use the 16-bit displacement; 0: use the sign-extended low byte |
| bx_in | input | 16 | BX contents |
| bp_in | input | 16 | BP contents |
| si_in | input | 16 | SI contents |
| di_in | input | 16 | DI contents |
| cs_in | input | 16 | Code segment register |
| ds_in | input | 16 | Data segment register |
| ss_in | input | 16 | Stack segment register |
| es_in | input | 16 | Extra segment register |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 2 | Override segment code |
| ea_out | output | 16 | Effective address |
| seg_out | output | 2 | Segment code in use |
| phys_out | output | 20 | Physical address |

## Verification
Some rules are checked on every clock cycle. The assertions check the override rule, the stack default for BP, the direct and register-indirect offsets, and the 16-bit sum of index plus wide displacement. They also check that the physical address matches the segment code and offset actually output, all one cycle after the inputs. Other behaviour appears only in the bench's scenarios. These are the sign extension of a negative byte displacement, the wrap of both the offset and the physical address, the reserved mode code, the three-term sum, and the zeroed outputs under reset.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT          = 3'd0,
        AM_PTR_BASE        = 3'd1,
        AM_PTR_INDEX       = 3'd2,
        AM_BASE_DISP       = 3'd3,
        AM_INDEX_DISP      = 3'd4,
        AM_BASE_INDEX      = 3'd5,
        AM_BASE_INDEX_DISP = 3'd6,
        AM_RESERVED        = 3'd7
    } am_e;

    typedef enum logic [1:0] {
        SR_CODE  = 2'd0,
        SR_DATA  = 2'd1,
        SR_STACK = 2'd2,
        SR_EXTRA = 2'd3
    } sr_e;

    function automatic logic am_has_base(input am_e m);
        return (m == AM_PTR_BASE) || (m == AM_BASE_DISP) ||
               (m == AM_BASE_INDEX) || (m == AM_BASE_INDEX_DISP);
    endfunction

    function automatic logic am_has_index(input am_e m);
        return (m == AM_PTR_INDEX) || (m == AM_INDEX_DISP) ||
               (m == AM_BASE_INDEX) || (m == AM_BASE_INDEX_DISP);
    endfunction

    function automatic logic am_has_disp(input am_e m);
        return (m == AM_BASE_DISP) || (m == AM_INDEX_DISP) ||
               (m == AM_BASE_INDEX_DISP);
    endfunction

    function automatic logic am_is_absolute(input am_e m);
        return (m == AM_DIRECT) || (m == AM_RESERVED);
    endfunction

endpackage

// File: rtl/eag_operand_sel.sv
module eag_operand_sel
    import eag_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NARROW_W = 8
) (
    input  am_e               mode,
    input  logic              base_pick,
    input  logic              index_pick,
    input  logic [ADDR_W-1:0] disp,
    input  logic              disp_wide,
    input  logic [ADDR_W-1:0] bx,
    input  logic [ADDR_W-1:0] bp,
    input  logic [ADDR_W-1:0] si,
    input  logic [ADDR_W-1:0] di,
    output logic [ADDR_W-1:0] base_term,
    output logic [ADDR_W-1:0] index_term,
    output logic [ADDR_W-1:0] disp_term,
    output logic              base_used
);
    localparam int EXT_W = ADDR_W - NARROW_W;

    logic [ADDR_W-1:0] base_val;
    logic [ADDR_W-1:0] index_val;
    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        base_val  = base_pick  ? bp : bx;
        index_val = index_pick ? di : si;
        disp_ext  = disp_wide ? disp
                              : {{EXT_W{disp[NARROW_W-1]}}, disp[NARROW_W-1:0]};

        base_used  = am_has_base(mode);
        base_term  = am_has_base(mode)  ? base_val  : '0;
        index_term = am_has_index(mode) ? index_val : '0;

        if (am_is_absolute(mode)) begin
            disp_term = disp;
        end else if (am_has_disp(mode)) begin
            disp_term = disp_ext;
        end else begin
            disp_term = '0;
        end
    end

endmodule

// File: rtl/eag_seg_sel.sv
module eag_seg_sel
    import eag_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_SEG = 4
) (
    input  logic                           base_used,
    input  logic                           base_pick,
    input  logic                           ovr_en,
    input  logic [$clog2(NUM_SEG)-1:0]     ovr_seg,
    input  logic [NUM_SEG-1:0][ADDR_W-1:0] seg_regs,
    output logic [$clog2(NUM_SEG)-1:0]     seg_code,
    output logic [ADDR_W-1:0]              seg_val
);
    localparam int SC_W = $clog2(NUM_SEG);

    logic [SC_W-1:0] dflt_code;

    always_comb begin
        if (base_used && base_pick) begin
            dflt_code = SC_W'(SR_STACK);
        end else begin
            dflt_code = SC_W'(SR_DATA);
        end
        seg_code = ovr_en ? ovr_seg : dflt_code;
        seg_val  = seg_regs[seg_code];
    end

endmodule

// File: rtl/eag_phys_calc.sv
module eag_phys_calc #(
    parameter int ADDR_W    = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic [ADDR_W-1:0]           base_term,
    input  logic [ADDR_W-1:0]           index_term,
    input  logic [ADDR_W-1:0]           disp_term,
    input  logic [ADDR_W-1:0]           seg_val,
    output logic [ADDR_W-1:0]           ea,
    output logic [ADDR_W+SEG_SHIFT-1:0] phys
);
    localparam int PA_W = ADDR_W + SEG_SHIFT;

    logic [PA_W-1:0] seg_base;

    always_comb begin
        ea       = base_term + index_term + disp_term;
        seg_base = {seg_val, {SEG_SHIFT{1'b0}}};
        phys     = seg_base + {{SEG_SHIFT{1'b0}}, ea};
    end

endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
    import eag_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SEG_SHIFT = 4,
    parameter int NARROW_W  = 8,
    parameter bit OUT_REG   = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [2:0]                     am_mode,
    input  logic                           base_pick,
    input  logic                           index_pick,
    input  logic [ADDR_W-1:0]              disp_in,
    input  logic                           disp_wide,
    input  logic [ADDR_W-1:0]              bx_in,
    input  logic [ADDR_W-1:0]              bp_in,
    input  logic [ADDR_W-1:0]              si_in,
    input  logic [ADDR_W-1:0]              di_in,
    input  logic [ADDR_W-1:0]              cs_in,
    input  logic [ADDR_W-1:0]              ds_in,
    input  logic [ADDR_W-1:0]              ss_in,
    input  logic [ADDR_W-1:0]              es_in,
    input  logic                           ovr_en,
    input  logic [1:0]                     ovr_seg,
    output logic [ADDR_W-1:0]              ea_out,
    output logic [1:0]                     seg_out,
    output logic [ADDR_W+SEG_SHIFT-1:0]    phys_out
);
    localparam int PA_W    = ADDR_W + SEG_SHIFT;
    localparam int NUM_SEG = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic [1:0]        seg;
        logic [PA_W-1:0]   phys;
    } res_t;

    logic [ADDR_W-1:0]              base_term;
    logic [ADDR_W-1:0]              index_term;
    logic [ADDR_W-1:0]              disp_term;
    logic                           base_used;
    logic [1:0]                     seg_code;
    logic [ADDR_W-1:0]              seg_val;
    logic [ADDR_W-1:0]              ea_c;
    logic [PA_W-1:0]                phys_c;
    logic [NUM_SEG-1:0][ADDR_W-1:0] seg_regs;

    res_t res_d;
    res_t res_q;

    // Segment codes index this array: 0 code, 1 data, 2 stack, 3 extra.
    assign seg_regs = {es_in, ss_in, ds_in, cs_in};

    eag_operand_sel #(
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W)
    ) u_opsel (
        .mode       (am_e'(am_mode)),
        .base_pick  (base_pick),
        .index_pick (index_pick),
        .disp       (disp_in),
        .disp_wide  (disp_wide),
        .bx         (bx_in),
        .bp         (bp_in),
        .si         (si_in),
        .di         (di_in),
        .base_term  (base_term),
        .index_term (index_term),
        .disp_term  (disp_term),
        .base_used  (base_used)
    );

    eag_seg_sel #(
        .ADDR_W  (ADDR_W),
        .NUM_SEG (NUM_SEG)
    ) u_segsel (
        .base_used (base_used),
        .base_pick (base_pick),
        .ovr_en    (ovr_en),
        .ovr_seg   (ovr_seg),
        .seg_regs  (seg_regs),
        .seg_code  (seg_code),
        .seg_val   (seg_val)
    );

    eag_phys_calc #(
        .ADDR_W    (ADDR_W),
        .SEG_SHIFT (SEG_SHIFT)
    ) u_phys (
        .base_term  (base_term),
        .index_term (index_term),
        .disp_term  (disp_term),
        .seg_val    (seg_val),
        .ea         (ea_c),
        .phys       (phys_c)
    );

    always_comb begin
        res_d      = '0;
        res_d.ea   = ea_c;
        res_d.seg  = seg_code;
        res_d.phys = phys_c;
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_d;
                end
            end
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign ea_out   = res_q.ea;
    assign seg_out  = res_q.seg;
    assign phys_out = res_q.phys;

endmodule

// File: rtl/eag_checker.sv
module eag_checker
    import eag_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SEG_SHIFT = 4,
    parameter bit OUT_REG   = 1'b1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [2:0]                  am_mode,
    input logic                        base_pick,
    input logic                        index_pick,
    input logic [ADDR_W-1:0]           disp_in,
    input logic                        disp_wide,
    input logic [ADDR_W-1:0]           bx_in,
    input logic [ADDR_W-1:0]           bp_in,
    input logic [ADDR_W-1:0]           si_in,
    input logic [ADDR_W-1:0]           di_in,
    input logic [ADDR_W-1:0]           cs_in,
    input logic [ADDR_W-1:0]           ds_in,
    input logic [ADDR_W-1:0]           ss_in,
    input logic [ADDR_W-1:0]           es_in,
    input logic                        ovr_en,
    input logic [1:0]                  ovr_seg,
    input logic [ADDR_W-1:0]           ea_out,
    input logic [1:0]                  seg_out,
    input logic [ADDR_W+SEG_SHIFT-1:0] phys_out
);
    localparam int PA_W = ADDR_W + SEG_SHIFT;

    logic              started;
    logic [ADDR_W-1:0] sv_seen;
    logic [PA_W-1:0]   phys_seen;
    logic [3:0][ADDR_W-1:0] segs_now;

    assign segs_now = {es_in, ss_in, ds_in, cs_in};

    generate
        if (OUT_REG) begin : g_seq
            logic [3:0][ADDR_W-1:0] segs_prev;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    started   <= 1'b0;
                    segs_prev <= '0;
                end else begin
                    started   <= 1'b1;
                    segs_prev <= segs_now;
                end
            end

            always_comb begin
                sv_seen   = segs_prev[seg_out];
                phys_seen = {sv_seen, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ea_out};
            end

            // R7: the override wins in every mode
            a_r7_override_wins: assert property (@(posedge clk) disable iff (!rst_n)
                started && $past(ovr_en) |-> seg_out == $past(ovr_seg));

            // R6: BP used as a base defaults to the stack segment
            a_r6_bp_stack: assert property (@(posedge clk) disable iff (!rst_n)
                started && $past(!ovr_en && base_pick && am_has_base(am_e'(am_mode)))
                |-> seg_out == 2'd2);

            // R1: absolute modes pass the 16-bit address through
            a_r1_absolute: assert property (@(posedge clk) disable iff (!rst_n)
                started && $past(am_mode == 3'd0 || am_mode == 3'd7)
                |-> ea_out == $past(disp_in));

            // R2: pointer modes output the chosen register
            a_r2_ptr_index: assert property (@(posedge clk) disable iff (!rst_n)
                started && $past(am_mode == 3'd2)
                |-> ea_out == $past(index_pick ? di_in : si_in));

            // R3: index plus wide displacement
            a_r3_index_wide: assert property (@(posedge clk) disable iff (!rst_n)
                started && $past(am_mode == 3'd4 && disp_wide)
                |-> ea_out == ADDR_W'($past(index_pick ? di_in : si_in) + $past(disp_in)));

            // R8: physical address agrees with the segment and offset output
            a_r8_phys_form: assert property (@(posedge clk) disable iff (!rst_n)
                started |-> phys_out == phys_seen);
        end else begin : g_cmb
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    started <= 1'b0;
                end else begin
                    started <= 1'b1;
                end
            end

            always_comb begin
                sv_seen   = segs_now[seg_out];
                phys_seen = {sv_seen, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ea_out};
            end

            // R7: the override wins in every mode
            a_r7_override_wins: assert property (@(posedge clk) disable iff (!rst_n)
                started && ovr_en |-> seg_out == ovr_seg);

            // R1: absolute modes pass the 16-bit address through
            a_r1_absolute: assert property (@(posedge clk) disable iff (!rst_n)
                started && (am_mode == 3'd0 || am_mode == 3'd7) |-> ea_out == disp_in);

            // R2: pointer modes output the chosen register
            a_r2_ptr_index: assert property (@(posedge clk) disable iff (!rst_n)
                started && am_mode == 3'd2 |-> ea_out == (index_pick ? di_in : si_in));

            // R8: physical address agrees with the segment and offset output
            a_r8_phys_form: assert property (@(posedge clk) disable iff (!rst_n)
                started |-> phys_out == phys_seen);

            // R6: BP used as a base defaults to the stack segment
            a_r6_bp_stack: assert property (@(posedge clk) disable iff (!rst_n)
                started && !ovr_en && base_pick && am_has_base(am_e'(am_mode))
                |-> seg_out == 2'd2);

            logic unused_ok;
            assign unused_ok = &{1'b0, bx_in, bp_in, disp_wide};
        end
    endgenerate

endmodule

bind seg_ea_gen eag_checker #(
    .ADDR_W    (ADDR_W),
    .SEG_SHIFT (SEG_SHIFT),
    .OUT_REG   (OUT_REG)
) u_eag_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .am_mode    (am_mode),
    .base_pick  (base_pick),
    .index_pick (index_pick),
    .disp_in    (disp_in),
    .disp_wide  (disp_wide),
    .bx_in      (bx_in),
    .bp_in      (bp_in),
    .si_in      (si_in),
    .di_in      (di_in),
    .cs_in      (cs_in),
    .ds_in      (ds_in),
    .ss_in      (ss_in),
    .es_in      (es_in),
    .ovr_en     (ovr_en),
    .ovr_seg    (ovr_seg),
    .ea_out     (ea_out),
    .seg_out    (seg_out),
    .phys_out   (phys_out)
);

// File: tb/tb_seg_ea_gen.sv
module tb_seg_ea_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  am_mode = '0;
    logic        base_pick = 1'b0;
    logic        index_pick = 1'b0;
    logic [15:0] disp_in = '0;
    logic        disp_wide = 1'b0;
    logic [15:0] bx_in = '0, bp_in = '0, si_in = '0, di_in = '0;
    logic [15:0] cs_in = '0, ds_in = '0, ss_in = '0, es_in = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic [15:0] ea_out;
    logic [1:0]  seg_out;
    logic [19:0] phys_out;

    int checks = 0;
    int fails  = 0;
    bit summary_done = 1'b0;

    typedef struct {
        logic [15:0] ea;
        logic [1:0]  seg;
        logic [19:0] phys;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    seg_ea_gen dut (
        .clk(clk), .rst_n(rst_n), .am_mode(am_mode), .base_pick(base_pick),
        .index_pick(index_pick), .disp_in(disp_in), .disp_wide(disp_wide),
        .bx_in(bx_in), .bp_in(bp_in), .si_in(si_in), .di_in(di_in),
        .cs_in(cs_in), .ds_in(ds_in), .ss_in(ss_in), .es_in(es_in),
        .ovr_en(ovr_en), .ovr_seg(ovr_seg),
        .ea_out(ea_out), .seg_out(seg_out), .phys_out(phys_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        end
    endtask

    function automatic exp_t model(input string tag);
        exp_t e;
        logic [15:0] b, x, d, sv;
        b = base_pick  ? bp_in : bx_in;
        x = index_pick ? di_in : si_in;
        d = disp_wide ? disp_in : {{8{disp_in[7]}}, disp_in[7:0]};
        case (am_mode)
            3'd1:    e.ea = b;
            3'd2:    e.ea = x;
            3'd3:    e.ea = b + d;
            3'd4:    e.ea = x + d;
            3'd5:    e.ea = b + x;
            3'd6:    e.ea = b + x + d;
            default: e.ea = disp_in;
        endcase
        if (ovr_en) e.seg = ovr_seg;
        else if (base_pick && (am_mode == 3'd1 || am_mode == 3'd3 ||
                               am_mode == 3'd5 || am_mode == 3'd6)) e.seg = 2'd2;
        else e.seg = 2'd1;
        case (e.seg)
            2'd0:    sv = cs_in;
            2'd1:    sv = ds_in;
            2'd2:    sv = ss_in;
            default: sv = es_in;
        endcase
        e.phys = {sv, 4'h0} + {4'h0, e.ea};
        e.tag  = tag;
        return e;
    endfunction

    task automatic set_regs(input logic [15:0] bx, bp, si, di);
        @(negedge clk);
        bx_in = bx; bp_in = bp; si_in = si; di_in = di;
    endtask

    task automatic set_segs(input logic [15:0] cs, ds, ss, es);
        @(negedge clk);
        cs_in = cs; ds_in = ds; ss_in = ss; es_in = es;
    endtask

    task automatic issue(input string tag, input logic [2:0] m, input logic bsel,
                         input logic isel, input logic [15:0] d, input logic dw,
                         input logic oen, input logic [1:0] osel);
        @(negedge clk);
        am_mode = m; base_pick = bsel; index_pick = isel;
        disp_in = d; disp_wide = dw; ovr_en = oen; ovr_seg = osel;
        exp_q.push_back(model(tag));
    endtask

    // Monitor: results appear one clock after the inputs (R9)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " ea"},   32'(ea_out),   32'(e.ea));
                check({e.tag, " seg"},  32'(seg_out),  32'(e.seg));
                check({e.tag, " phys"}, 32'(phys_out), 32'(e.phys));
            end
        end
    end

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'h1ACE_B00C;
        bx_in = 16'h1111; si_in = 16'h2222; cs_in = 16'h3000;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check("R9 reset ea",   32'(ea_out),   32'h0);
        check("R9 reset seg",  32'(seg_out),  32'h0);
        check("R9 reset phys", 32'(phys_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        set_segs(16'h1000, 16'h2000, 16'h3000, 16'h4000);
        set_regs(16'h1000, 16'h0800, 16'h0040, 16'h0123);

        issue("R1 direct narrow", 3'd0, 1'b1, 1'b0, 16'hABCD, 1'b0, 1'b0, 2'd0);
        issue("R1 reserved code", 3'd7, 1'b1, 1'b1, 16'h8001, 1'b1, 1'b0, 2'd0);
        issue("R2 R6 ptr BX",      3'd1, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b0, 2'd0);
        issue("R2 R6 ptr BP",      3'd1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0);
        issue("R2 R6 ptr SI",      3'd2, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0);
        issue("R2 ptr DI",         3'd2, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 2'd0);
        issue("R3 base negbyte",   3'd3, 1'b0, 1'b0, 16'h1280, 1'b0, 1'b0, 2'd0);
        issue("R3 base wide",      3'd3, 1'b1, 1'b0, 16'h1243, 1'b1, 1'b0, 2'd0);
        issue("R3 index posbyte",  3'd4, 1'b0, 1'b0, 16'hFF05, 1'b0, 1'b0, 2'd0);
        issue("R3 index wide",     3'd4, 1'b1, 1'b1, 16'hF000, 1'b1, 1'b0, 2'd0);
        issue("R4 BX+SI",          3'd5, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0);
        issue("R4 R6 BP+DI",       3'd5, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 2'd0);
        issue("R4 BX+DI+disp",     3'd6, 1'b0, 1'b1, 16'h00FE, 1'b0, 1'b0, 2'd0);

        set_regs(16'hFFF8, 16'hFFF0, 16'hFFFF, 16'h0020);
        issue("R5 R4 wrap BP+DI+d", 3'd6, 1'b1, 1'b1, 16'h0001, 1'b0, 1'b0, 2'd0);
        issue("R5 wrap BX+wide",    3'd3, 1'b0, 1'b0, 16'h0010, 1'b1, 1'b0, 2'd0);
        issue("R7 ovr ES on BP",    3'd1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 2'd3);
        issue("R7 ovr CS direct",   3'd0, 1'b0, 1'b0, 16'h0100, 1'b0, 1'b1, 2'd0);
        issue("R7 ovr SS on SI",    3'd2, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 2'd2);
        issue("R7 ovr DS on BP",    3'd5, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 2'd1);

        set_segs(16'hFFFF, 16'hF000, 16'h0001, 16'h8000);
        issue("R8 phys wrap",       3'd0, 1'b0, 1'b0, 16'h0020, 1'b0, 1'b1, 2'd0);
        issue("R8 phys DS",         3'd0, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b0, 2'd0);
        issue("R8 phys SS",         3'd3, 1'b1, 1'b0, 16'h0005, 1'b0, 1'b0, 2'd0);

        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = lfsr * 32'd1103515245 + 32'd12345;
            set_regs(lfsr[15:0], lfsr[31:16], lfsr[23:8], ~lfsr[15:0]);
            set_segs(lfsr[31:16] ^ 16'h5A5A, lfsr[15:0], ~lfsr[31:16], lfsr[27:12]);
            issue("R3 R4 R8 sweep", lfsr[2:0], lfsr[3], lfsr[4], lfsr[31:16] ^ lfsr[15:0],
                  lfsr[5], lfsr[6] & lfsr[7], lfsr[9:8]);
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        // R9: asynchronous reset clears results mid-run
        check("R9 midrun reset ea",   32'(ea_out),   32'h0);
        check("R9 midrun reset phys", 32'(phys_out), 32'h0);
        summary();
        $finish;
    end

endmodule